// File: doc/BRIEF.md
# OSD Character Row Vertical Scaler

This block produces the vertical timing for one on-screen-display character row. A character cell holds 18 font lines, numbered 0 to 17. The block stretches the cell vertically by showing some font lines more than once. A 7-bit weight code chooses which lines are repeated. The five low bits are binary weights, and each one adds one extra copy to a fixed, evenly spread set of font lines. The two high bits add whole copies of the full cell.

A rising edge on the vertical flyback input starts a frame. The block then counts horizontal line strobes until a programmed start delay has passed. After that, every strobe moves the display on by one scan line. For each scan line the block reports which font line to fetch and raises a row-active flag. When the last copy of font line 17 ends, it issues a one-cycle done pulse. It then stays idle until the next flyback edge.

Top module: `osd_row_vscaler`

## Requirements
- R1: During and after reset, with no flyback edge yet seen, `row_active_o` is 0, `font_line_o` is 0 and `row_done_o` is 0.
- R2: A rising edge on `vflb_i` starts a frame. `row_active_o` rises with `font_line_o` = 0 in the cycle after the (4*V+1)-th `hline_i` strobe that follows the edge, where V is `vstart_i` sampled at the edge. Before that strobe, `row_active_o` stays 0.
- R3: A rising edge on `vflb_i` while a row is being shown aborts it. In the next cycle `row_active_o` is 0 and `font_line_o` is 0, and the delay count starts over.
- R4: Each low weight bit adds one extra copy to the font lines in its set: bit 0 to line 8; bit 1 to lines 4 and 13; bit 2 to lines 2, 6, 10 and 14; bit 3 to the odd lines 1 to 15; bit 4 to lines 1 to 16.
- R5: The field `weight_i[6:5]`, read as an unsigned value n from 0 to 3, adds n extra copies to every one of the 18 font lines.
- R6: Font lines are shown in ascending order from 0 to 17. All copies of a line are contiguous. The number of active scan lines in a row is 18*(1+n) + `weight_i[4:0]`.
- R7: `weight_i` and `vstart_i` are sampled only at the flyback edge. Changing them later in the frame does not change the row being shown.
- R8: The cycle after the strobe that ends the last copy of line 17, `row_done_o` is 1 for exactly one cycle and `row_active_o` falls in that same cycle.
- R9: After the done pulse, further strobes have no effect until the next flyback edge: `row_active_o` stays 0, `font_line_o` stays 0 and `row_done_o` stays 0.
- R10: `font_line_o` changes only in the cycle after an `hline_i` strobe. Gaps between strobes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vflb_i | input | 1 | Vertical flyback level; a rising edge starts a frame |
| hline_i | input | 1 | One-cycle strobe, one per horizontal scan line |
| vstart_i | input | VSW | Vertical start value V; the delay is 4*V+1 lines |
| weight_i | input | 7 | Repeat weight code: [4:0] binary weights, [6:5] whole-cell repeats |
| font_line_o | output | 5 | Font line to fetch for the current scan line (0 to 17) |
| row_active_o | output | 1 | The row is being shown on this scan line |
| row_done_o | output | 1 | One-cycle pulse after the last scan line of the row |

## Verification
The bench drives each low weight bit on its own:
- Bit 0 shows whether the single middle line is doubled.
- Bits 1 and 2 show whether the evenly spread sets are placed correctly.
- Bits 3 and 4 test the large alternating and full-span sets.

It then drives the whole-cell field at each of its values, alone and mixed with low bits. Mixing them separates the per-line bit masks from the uniform repeat, and it exposes overlaps where one line is selected by several bits.

Other runs cover the following:
- Start values of 0 and above, which separate the +1 line offset from the x4 scaling.
- Gaps between strobes, which show that the line index moves only on strobes.
- Scrambling the inputs after the edge, which checks that they are latched.
- A mid-row flyback, which checks that the row restarts cleanly.

// File: rtl/osd_vs_pkg.sv
package osd_vs_pkg;
  localparam int FONT_LINES = 18;
  localparam int LINE_W     = 5;
  localparam int N_WBITS    = 5;
  localparam int WEIGHT_W   = 7;
  localparam int COPY_W     = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_DONE   = 2'd3
  } vs_state_e;

  // Set of font lines that receive one extra copy from weight bit b
  function automatic logic [FONT_LINES-1:0] line_mask(input int b);
    logic [FONT_LINES-1:0] m;
    m = '0;
    case (b)
      0: m[8] = 1'b1;
      1: begin m[4] = 1'b1; m[13] = 1'b1; end
      2: begin m[2] = 1'b1; m[6] = 1'b1; m[10] = 1'b1; m[14] = 1'b1; end
      3: for (int i = 1; i <= 15; i += 2) m[i] = 1'b1;
      default: for (int i = 1; i <= 16; i++) m[i] = 1'b1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/osd_vs_delay.sv
module osd_vs_delay #(
  parameter int VSW = 8,
  localparam int DW = VSW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           edge_i,
  input  logic           strobe_i,
  input  logic [VSW-1:0] vstart_i,
  output logic           expire_o
);
  logic          run_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] target_q;
  logic          last_line;

  assign last_line = (cnt_q == target_q - DW'(1));
  assign expire_o  = run_q & strobe_i & ~edge_i & last_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      target_q <= DW'(1);
    end else if (edge_i) begin
      run_q    <= 1'b1;
      cnt_q    <= '0;
      target_q <= {vstart_i, 2'b01};
    end else if (run_q && strobe_i) begin
      if (last_line) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + DW'(1);
      end
    end
  end
endmodule

// File: rtl/osd_vs_copies.sv
module osd_vs_copies
  import osd_vs_pkg::*;
(
  input  logic [LINE_W-1:0]   line_i,
  input  logic [WEIGHT_W-1:0] weight_i,
  output logic [COPY_W-1:0]   copies_o
);
  logic [N_WBITS-1:0] hit;

  for (genvar b = 0; b < N_WBITS; b++) begin : g_bit
    localparam logic [FONT_LINES-1:0] MASK = line_mask(b);
    logic in_set;
    always_comb begin
      in_set = 1'b0;
      for (int l = 0; l < FONT_LINES; l++)
        if (line_i == LINE_W'(l)) in_set = MASK[l];
    end
    assign hit[b] = weight_i[b] & in_set;
  end

  always_comb begin
    copies_o = COPY_W'(1) + COPY_W'(weight_i[WEIGHT_W-1:N_WBITS]);
    for (int b = 0; b < N_WBITS; b++)
      copies_o = copies_o + COPY_W'(hit[b]);
  end
endmodule

// File: rtl/osd_vs_seq.sv
module osd_vs_seq
  import osd_vs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic              strobe_i,
  input  logic              expire_i,
  input  logic [COPY_W-1:0] copies_i,
  output logic [LINE_W-1:0] line_o,
  output logic              active_o,
  output logic              done_o
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FONT_LINES - 1);

  vs_state_e         state_q;
  logic [LINE_W-1:0] line_q;
  logic [COPY_W-1:0] copy_q;
  logic              done_q;
  logic              last_copy;

  assign last_copy = (copy_q == copies_i - COPY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      copy_q  <= '0;
      done_q  <= 1'b0;
    end else if (edge_i) begin
      state_q <= ST_WAIT;
      line_q  <= '0;
      copy_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_WAIT: if (expire_i) begin
          state_q <= ST_ACTIVE;
          line_q  <= '0;
          copy_q  <= '0;
        end
        ST_ACTIVE: if (strobe_i) begin
          if (last_copy) begin
            copy_q <= '0;
            if (line_q == LAST_LINE) begin
              state_q <= ST_DONE;
              line_q  <= '0;
              done_q  <= 1'b1;
            end else begin
              line_q <= line_q + LINE_W'(1);
            end
          end else begin
            copy_q <= copy_q + COPY_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign line_o   = line_q;
  assign active_o = (state_q == ST_ACTIVE);
  assign done_o   = done_q;
endmodule

// File: rtl/osd_row_vscaler.sv
module osd_row_vscaler
  import osd_vs_pkg::*;
#(
  parameter int VSW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vflb_i,
  input  logic                hline_i,
  input  logic [VSW-1:0]      vstart_i,
  input  logic [WEIGHT_W-1:0] weight_i,
  output logic [LINE_W-1:0]   font_line_o,
  output logic                row_active_o,
  output logic                row_done_o
);
  logic                vflb_q;
  logic                vedge;
  logic                expire;
  logic [WEIGHT_W-1:0] weight_q;
  logic [COPY_W-1:0]   copies;
  logic [LINE_W-1:0]   line;

  assign vedge = vflb_i & ~vflb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vflb_q   <= 1'b0;
      weight_q <= '0;
    end else begin
      vflb_q <= vflb_i;
      if (vedge) weight_q <= weight_i;
    end
  end

  osd_vs_delay #(.VSW(VSW)) u_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (vedge),
    .strobe_i (hline_i),
    .vstart_i (vstart_i),
    .expire_o (expire)
  );

  osd_vs_copies u_copies (
    .line_i   (line),
    .weight_i (weight_q),
    .copies_o (copies)
  );

  osd_vs_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (vedge),
    .strobe_i (hline_i),
    .expire_i (expire),
    .copies_i (copies),
    .line_o   (line),
    .active_o (row_active_o),
    .done_o   (row_done_o)
  );

  assign font_line_o = line;
endmodule

// File: rtl/osd_vs_checker.sv
module osd_vs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hline_i,
  input logic [4:0] font_line_o,
  input logic       row_active_o,
  input logic       row_done_o
);
  AST_LINE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    font_line_o <= 5'd17); // R6
  AST_IDLE_LINE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_active_o |-> font_line_o == 5'd0); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_done_o |=> !row_done_o); // R8
  AST_DONE_ENDS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_done_o |-> !row_active_o && $past(row_active_o)); // R8
  AST_START_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(row_active_o) |-> $past(hline_i) && font_line_o == 5'd0); // R2
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_active_o && $past(row_active_o) && font_line_o != $past(font_line_o))
      |-> $past(hline_i) && font_line_o == $past(font_line_o) + 5'd1); // R10
endmodule

bind osd_row_vscaler osd_vs_checker u_vs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hline_i      (hline_i),
  .font_line_o  (font_line_o),
  .row_active_o (row_active_o),
  .row_done_o   (row_done_o)
);

// File: tb/osd_row_vscaler_tb_top.sv
module osd_row_vscaler_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vflb_i = 1'b0;
  logic       hline_i = 1'b0;
  logic [7:0] vstart_i = '0;
  logic [6:0] weight_i = '0;
  logic [4:0] font_line_o;
  logic       row_active_o;
  logic       row_done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  osd_row_vscaler dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_copies(input logic [6:0] w, input int l);
    int c;
    c = 1 + int'(w[6:5]);
    if (w[0] && l == 8) c++;
    if (w[1] && (l == 4 || l == 13)) c++;
    if (w[2] && (l == 2 || l == 6 || l == 10 || l == 14)) c++;
    if (w[3] && (l % 2 == 1) && l <= 15) c++;
    if (w[4] && l >= 1 && l <= 16) c++;
    return c;
  endfunction

  task automatic strobe(input int gap);
    @(negedge clk_i) hline_i = 1'b1;
    @(negedge clk_i) hline_i = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  task automatic flyback(input logic [7:0] vs, input logic [6:0] w);
    @(negedge clk_i);
    vstart_i = vs; weight_i = w; vflb_i = 1'b1;
    @(negedge clk_i);
    vstart_i = vs + 8'd5; weight_i = ~w;  // R7: later changes must be ignored
    repeat (2) @(negedge clk_i);
    vflb_i = 1'b0;
    chk("R3 active after edge", row_active_o, 0);
    chk("R3 line after edge", font_line_o, 0);
  endtask

  task automatic delay_phase(input logic [7:0] vs, input int gap);
    int d = 4 * int'(vs) + 1;
    for (int i = 1; i <= d; i++) begin
      strobe(gap);
      if (i < d) chk("R2 idle during delay", row_active_o, 0);
    end
    chk("R2 active after delay", row_active_o, 1);
    chk("R2 first line", font_line_o, 0);
  endtask

  task automatic show_row(input logic [6:0] w, input int gap);
    int shown = 0;
    for (int l = 0; l < 18; l++) begin
      for (int k = 0; k < exp_copies(w, l); k++) begin
        chk("R4 R5 R6 line", font_line_o, l);
        chk("R6 active", row_active_o, 1);
        if (row_active_o) shown++;
        strobe(0);
        if (gap > 0) begin
          repeat (gap) @(negedge clk_i);
          if (!(l == 17 && k == exp_copies(w, l) - 1))
            chk("R10 stable in gap", font_line_o,
                (k == exp_copies(w, l) - 1) ? l + 1 : l);
        end
        if (l == 17 && k == exp_copies(w, l) - 1 && gap == 0) begin
          chk("R8 done pulse", row_done_o, 1);
          chk("R8 active falls", row_active_o, 0);
        end
      end
    end
    chk("R6 row length", shown, 18 * (1 + int'(w[6:5])) + int'(w[4:0]));
    @(negedge clk_i);
    chk("R8 done one cycle", row_done_o, 0);
  endtask

  task automatic run_row(input logic [7:0] vs, input logic [6:0] w, input int gap);
    flyback(vs, w);
    delay_phase(vs, gap);
    show_row(w, gap);
  endtask

  task automatic t_reset;
    chk("R1 active", row_active_o, 0);
    chk("R1 line", font_line_o, 0);
    chk("R1 done", row_done_o, 0);
    strobe(0);
    chk("R1 strobe without edge", row_active_o, 0);
  endtask

  task automatic t_single_bits;
    run_row(8'd0, 7'h00, 0);
    for (int b = 0; b < 5; b++) run_row(8'd0, 7'(1 << b), 0);
  endtask

  task automatic t_whole;
    run_row(8'd1, 7'h20, 0);  // R5 n=1
    run_row(8'd0, 7'h40, 0);  // R5 n=2
    run_row(8'd0, 7'h60, 0);  // R5 n=3
    run_row(8'd2, 7'h7F, 0);  // R5 R4 mixed maximum
    run_row(8'd0, 7'h35, 0);
  endtask

  task automatic t_gaps;
    run_row(8'd3, 7'h0B, 2);  // R10
  endtask

  task automatic t_restart;
    flyback(8'd1, 7'h1F);
    delay_phase(8'd1, 0);
    repeat (6) strobe(0);
    chk("R3 active mid-row", row_active_o, 1);
    flyback(8'd0, 7'h02);
    chk("R3 aborted", row_active_o, 0);
    delay_phase(8'd0, 0);
    show_row(7'h02, 0);
  endtask

  task automatic t_after_done;
    run_row(8'd0, 7'h01, 0);
    for (int i = 0; i < 5; i++) begin
      strobe(0);
      chk("R9 active stays low", row_active_o, 0);
      chk("R9 line stays 0", font_line_o, 0);
      chk("R9 no done", row_done_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single_bits();
    t_whole();
    t_gaps();
    t_restart();
    t_after_done();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule